// File: doc/BRIEF.md
# SPI-Controlled NAND Bridge and Output Expander

This block is an SPI slave placed between a host processor and an 8-bit parallel NAND flash. The host opens a frame by pulling chip select low and sends an opcode byte. The opcode chooses one of five actions: stream bytes onto the NAND data bus, stream bytes back from the NAND bus, load an 8-bit control register, or set or clear one extra output. The control register drives the NAND address-latch, command-latch and chip-enable pins directly, together with four LEDs and a fan enable. A fifth LED lives outside the register and has its own pair of opcodes.

The SPI pins are oversampled in the system clock domain. Single-line bytes arrive on `spi_io0`, while NAND write payloads use both data lines. NAND write-enable and read-enable pulses come from a shared strobe generator whose width is a parameter. Read data is prefetched one byte ahead, so the next byte is always waiting in the transmit shifter before the host clocks it out.

Top module: `spinand_bridge`

## Requirements
- R1: After reset every control output is 0 except `nand_ce_n`, which is 1. `led_q` is 0, both NAND strobes are high (idle) and `spi_miso` is 0.
- R2: The frame opcode 0x09 loads the following byte, received MSB first on `spi_io0` and sampled on rising SCLK edges, into the control register. The register drives the outputs with no inversion. Bit 0 drives LED1 (`led_q[0]`), bit 1 drives LED3 (`led_q[2]`), bit 2 drives LED2 (`led_q[1]`) and bit 3 drives LED4 (`led_q[3]`). Bit 4 drives `fan_on`, bit 5 `nand_ale`, bit 6 `nand_cle` and bit 7 `nand_ce_n`.
- R3: A frame whose opcode is 0x0C sets `led_q[4]` and one whose opcode is 0x0D clears it. Neither opcode alters the control register.
- R4: After opcode 0x08, payload bytes arrive two bits per rising SCLK edge. The first edge carries bit 7 on `spi_io1` and bit 6 on `spi_io0`, and the remaining bit pairs follow in descending order. Each payload byte is placed on `nand_dq_out` in arrival order, and one low pulse of `nand_we_n` is issued for it. The data stays stable across the rising edge of `nand_we_n`.
- R5: In a write frame, the last full byte received before chip select rises is the trailing idle byte. It produces no write pulse.
- R6: After opcode 0x0A and one idle byte, each byte the host clocks is a NAND byte sent MSB first on `spi_miso`. `spi_miso` changes after falling SCLK edges. Each byte is fetched by a `nand_re_n` pulse and captured on its rising edge. A fetch starts when the idle byte completes and again when each data byte completes, so N data bytes cost N+1 fetches.
- R7: Opcode 0x0B behaves like 0x0A, except that four idle bytes come before the first data byte.
- R8: Raising chip select part-way through a byte discards that byte. The control register and LED5 stay as they were, and the next frame is decoded from a fresh opcode. A write payload byte that was already followed by a complete byte is still written.
- R9: Each NAND strobe pulse stays low for at least two system clocks, and `nand_we_n` and `nand_re_n` are never low at the same time.
- R10: A frame with any other opcode produces no strobe and changes no output.
- R11: `spi_miso` is 0 whenever no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_io0 | input | 1 | SPI data line 0 (MOSI) |
| spi_io1 | input | 1 | SPI data line 1, used for dual-line write payloads |
| spi_miso | output | 1 | SPI read data to host |
| nand_dq_out | output | 8 | NAND data bus, outgoing value |
| nand_dq_oe | output | 1 | NAND data bus output enable |
| nand_dq_in | input | 8 | NAND data bus, incoming value |
| nand_we_n | output | 1 | NAND write enable, active low |
| nand_re_n | output | 1 | NAND read enable, active low |
| nand_ale | output | 1 | NAND address latch enable |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| fan_on | output | 1 | Fan enable |
| led_q | output | 5 | LED1..LED5 drive, bit i is LED(i+1) |

## Verification
A wrong opcode state shows up within the next full byte. A single-line payload read as dual, or the reverse, scrambles the NAND write data at the very next write-enable edge. A lost or extra idle-byte count shifts the whole read stream by one byte, and the first byte returned over `spi_miso` exposes it. A stale pending-byte flag turns up as one write pulse too many or too few, so the bench counts strobe edges per frame, not only data values. A control register that latches a partial byte is caught by reading all nine expander outputs right after an aborted frame.

// File: rtl/spinand_pkg.sv
package spinand_pkg;

   localparam logic [7:0] OP_NAND_WR  = 8'h08;
   localparam logic [7:0] OP_CFG_LD   = 8'h09;
   localparam logic [7:0] OP_NAND_RD  = 8'h0A;
   localparam logic [7:0] OP_NAND_RDF = 8'h0B;
   localparam logic [7:0] OP_AUX_ON   = 8'h0C;
   localparam logic [7:0] OP_AUX_OFF  = 8'h0D;

   // control register bit positions
   localparam int CB_LED1 = 0;
   localparam int CB_LED3 = 1;
   localparam int CB_LED2 = 2;
   localparam int CB_LED4 = 3;
   localparam int CB_FAN  = 4;
   localparam int CB_ALE  = 5;
   localparam int CB_CLE  = 6;
   localparam int CB_CEN  = 7;

   localparam logic [7:0] CFG_RESET = 8'h80;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_WRITE,
      PH_CFG,
      PH_SKIP,
      PH_READ,
      PH_DRAIN
   } phase_t;

endpackage

// File: rtl/spi_sampler.sv
module spi_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic io0,
   input  logic io1,
   output logic frame_act,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic d0,
   output logic d1
);
   // vector layout {io1, io0, cs_n, sclk}
   localparam logic [3:0] SYNC_RST = 4'b0010;

   logic [3:0] stage [SYNC_STAGES];
   logic       sclk_d;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("spi_sampler: SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= SYNC_RST;
            else        stage[g] <= {io1, io0, cs_n, sclk};
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[g] <= SYNC_RST;
            else        stage[g] <= stage[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= stage[SYNC_STAGES-1][0];
   end

   assign frame_act = ~stage[SYNC_STAGES-1][1];
   assign sclk_rise = stage[SYNC_STAGES-1][0] & ~sclk_d;
   assign sclk_fall = ~stage[SYNC_STAGES-1][0] & sclk_d;
   assign d0        = stage[SYNC_STAGES-1][2];
   assign d1        = stage[SYNC_STAGES-1][3];

endmodule

// File: rtl/byte_rx.sv
module byte_rx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_act,
   input  logic         sclk_rise,
   input  logic         d0,
   input  logic         d1,
   input  logic         dual,
   output logic         byte_vld,
   output logic [W-1:0] byte_q,
   output logic         mid_byte
);
   localparam int CNT_W = $clog2(W);
   localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(W - 1);
   localparam logic [CNT_W-1:0] LAST_TWO = CNT_W'(W / 2 - 1);

   if ((W % 2) != 0 || W < 4) begin : g_chk_w
      $error("byte_rx: W must be even and at least 4");
   end

   logic [CNT_W-1:0] cnt;
   logic [W-1:0]     sr;
   logic [W-1:0]     sr_nxt;
   logic             at_last;

   always_comb begin
      if (dual) begin
         sr_nxt  = {sr[W-3:0], d1, d0};
         at_last = (cnt == LAST_TWO);
      end else begin
         sr_nxt  = {sr[W-2:0], d0};
         at_last = (cnt == LAST_ONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sr       <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (!frame_act) begin
            cnt <= '0;
            sr  <= '0;
         end else if (sclk_rise) begin
            sr <= sr_nxt;
            if (at_last) begin
               cnt      <= '0;
               byte_vld <= 1'b1;
               byte_q   <= sr_nxt;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign mid_byte = (cnt != '0);

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
   parameter int PULSE_CLKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic strobe_n,
   output logic ending
);
   localparam int PW = (PULSE_CLKS > 2) ? $clog2(PULSE_CLKS) : 1;

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_n <= 1'b1;
         cnt      <= '0;
      end else if (!strobe_n) begin
         if (cnt == '0) strobe_n <= 1'b1;
         else           cnt      <= cnt - 1'b1;
      end else if (start) begin
         strobe_n <= 1'b0;
         cnt      <= PW'(PULSE_CLKS - 1);
      end
   end

   assign ending = ~strobe_n & (cnt == '0);

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
   import spinand_pkg::*;
#(
   parameter int W         = 8,
   parameter int NORM_SKIP = 1,
   parameter int FAST_SKIP = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_act,
   input  logic         byte_vld,
   input  logic [W-1:0] byte_q,
   output logic         dual_mode,
   output logic         dq_oe,
   output logic         wr_start,
   output logic [W-1:0] wr_byte,
   output logic         rd_start,
   output logic [W-1:0] cfg_q,
   output logic         aux_q
);
   localparam int SKIP_MAX = (FAST_SKIP > NORM_SKIP) ? FAST_SKIP : NORM_SKIP;
   localparam int SKIP_W   = $clog2(SKIP_MAX + 1);

   if (NORM_SKIP < 1 || FAST_SKIP < 1) begin : g_chk_skip
      $error("frame_ctrl: idle byte counts must be at least 1");
   end

   phase_t            phase;
   logic [SKIP_W-1:0] skip_left;
   logic [W-1:0]      pend;
   logic              pend_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OPCODE;
         skip_left <= '0;
         pend      <= '0;
         pend_vld  <= 1'b0;
         wr_start  <= 1'b0;
         wr_byte   <= '0;
         rd_start  <= 1'b0;
         cfg_q     <= CFG_RESET;
         aux_q     <= 1'b0;
      end else begin
         wr_start <= 1'b0;
         rd_start <= 1'b0;
         if (!frame_act) begin
            phase     <= PH_OPCODE;
            pend_vld  <= 1'b0;
            skip_left <= '0;
         end else if (byte_vld) begin
            unique case (phase)
               PH_OPCODE: begin
                  if (byte_q == OP_NAND_WR) begin
                     phase <= PH_WRITE;
                  end else if (byte_q == OP_CFG_LD) begin
                     phase <= PH_CFG;
                  end else if (byte_q == OP_NAND_RD) begin
                     phase     <= PH_SKIP;
                     skip_left <= SKIP_W'(NORM_SKIP);
                  end else if (byte_q == OP_NAND_RDF) begin
                     phase     <= PH_SKIP;
                     skip_left <= SKIP_W'(FAST_SKIP);
                  end else if (byte_q == OP_AUX_ON) begin
                     aux_q <= 1'b1;
                     phase <= PH_DRAIN;
                  end else if (byte_q == OP_AUX_OFF) begin
                     aux_q <= 1'b0;
                     phase <= PH_DRAIN;
                  end else begin
                     phase <= PH_DRAIN;
                  end
               end
               PH_WRITE: begin
                  // a byte is committed only once its successor completes
                  if (pend_vld) begin
                     wr_start <= 1'b1;
                     wr_byte  <= pend;
                  end
                  pend     <= byte_q;
                  pend_vld <= 1'b1;
               end
               PH_CFG: begin
                  cfg_q <= byte_q;
                  phase <= PH_DRAIN;
               end
               PH_SKIP: begin
                  if (skip_left == SKIP_W'(1)) begin
                     rd_start <= 1'b1;
                     phase    <= PH_READ;
                  end else begin
                     skip_left <= skip_left - 1'b1;
                  end
               end
               PH_READ:  rd_start <= 1'b1;
               PH_DRAIN: phase    <= PH_DRAIN;
               default:  phase    <= PH_DRAIN;
            endcase
         end
      end
   end

   assign dual_mode = (phase == PH_WRITE);
   assign dq_oe     = (phase == PH_WRITE);

endmodule

// File: rtl/spinand_bridge.sv
module spinand_bridge
   import spinand_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STROBE_CLKS = 2,
   parameter int NORM_SKIP   = 1,
   parameter int FAST_SKIP   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_sclk,
   input  logic       spi_cs_n,
   input  logic       spi_io0,
   input  logic       spi_io1,
   output logic       spi_miso,
   output logic [7:0] nand_dq_out,
   output logic       nand_dq_oe,
   input  logic [7:0] nand_dq_in,
   output logic       nand_we_n,
   output logic       nand_re_n,
   output logic       nand_ale,
   output logic       nand_cle,
   output logic       nand_ce_n,
   output logic       fan_on,
   output logic [4:0] led_q
);
   localparam int W = 8;

   if (STROBE_CLKS < 2) begin : g_chk_strobe
      $error("spinand_bridge: STROBE_CLKS must be at least 2");
   end

   logic         frame_act, sclk_rise, sclk_fall, d0, d1;
   logic         dual_mode, byte_vld, mid_byte;
   logic [W-1:0] byte_q;
   logic         wr_start, rd_start, wr_end, rd_end;
   logic [W-1:0] wr_byte, cfg_q, tx_sr;
   logic         aux_q;

   spi_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
      .io0(spi_io0), .io1(spi_io1), .frame_act(frame_act),
      .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .d0(d0), .d1(d1)
   );

   byte_rx #(.W(W)) u_rx (
      .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .sclk_rise(sclk_rise),
      .d0(d0), .d1(d1), .dual(dual_mode), .byte_vld(byte_vld),
      .byte_q(byte_q), .mid_byte(mid_byte)
   );

   frame_ctrl #(.W(W), .NORM_SKIP(NORM_SKIP), .FAST_SKIP(FAST_SKIP)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .byte_vld(byte_vld),
      .byte_q(byte_q), .dual_mode(dual_mode), .dq_oe(nand_dq_oe),
      .wr_start(wr_start), .wr_byte(wr_byte), .rd_start(rd_start),
      .cfg_q(cfg_q), .aux_q(aux_q)
   );

   strobe_gen #(.PULSE_CLKS(STROBE_CLKS)) u_we (
      .clk(clk), .rst_n(rst_n), .start(wr_start & nand_re_n),
      .strobe_n(nand_we_n), .ending(wr_end)
   );

   strobe_gen #(.PULSE_CLKS(STROBE_CLKS)) u_re (
      .clk(clk), .rst_n(rst_n), .start(rd_start & nand_we_n),
      .strobe_n(nand_re_n), .ending(rd_end)
   );

   // transmit shifter: load on read-enable rising edge, shift after falls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tx_sr <= '0;
      else if (!frame_act)              tx_sr <= '0;
      else if (rd_end)                  tx_sr <= nand_dq_in;
      else if (sclk_fall && mid_byte)   tx_sr <= {tx_sr[W-2:0], 1'b0};
   end

   logic unused_wr_end;
   assign unused_wr_end = wr_end;

   assign spi_miso    = tx_sr[W-1];
   assign nand_dq_out = wr_byte;
   assign nand_ale    = cfg_q[CB_ALE];
   assign nand_cle    = cfg_q[CB_CLE];
   assign nand_ce_n   = cfg_q[CB_CEN];
   assign fan_on      = cfg_q[CB_FAN];
   assign led_q       = {aux_q, cfg_q[CB_LED4], cfg_q[CB_LED3],
                         cfg_q[CB_LED2], cfg_q[CB_LED1]};

endmodule

// File: rtl/spinand_bridge_chk.sv
module spinand_bridge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_act,
   input logic       nand_we_n,
   input logic       nand_re_n,
   input logic [7:0] nand_dq_out,
   input logic [8:0] exp_bus,
   input logic       spi_miso
);
   // R9
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |=> !nand_we_n);

   // R9
   re_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_re_n) |=> !nand_re_n);

   // R9
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R4
   wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> $stable(nand_dq_out));

   // R8
   exp_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(exp_bus) |-> $past(frame_act));

   // R11
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_act |=> !spi_miso);

endmodule

bind spinand_bridge spinand_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .frame_act(frame_act),
   .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
   .exp_bus({aux_q, cfg_q}), .spi_miso(spi_miso)
);

// File: tb/test_spinand_bridge.sv
module test_spinand_bridge;
   localparam int HALF = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, io0 = 1'b0, io1 = 1'b0;
   logic [7:0] dq_in;
   logic       miso, dq_oe, we_n, re_n, ale, cle, ce_n, fan;
   logic [7:0] dq_out;
   logic [4:0] led;

   int checks = 0, fails = 0;
   int we_cnt = 0, re_cnt = 0;
   bit mon_en = 1'b0;
   logic [7:0] wq[$];

   always #10 clk = ~clk;

   spinand_bridge i_spinand_bridge (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_io0(io0), .spi_io1(io1), .spi_miso(miso),
      .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in),
      .nand_we_n(we_n), .nand_re_n(re_n), .nand_ale(ale), .nand_cle(cle),
      .nand_ce_n(ce_n), .fan_on(fan), .led_q(led)
   );

   function automatic logic [7:0] pat(int k);
      return 8'(k * 37 + 5);
   endfunction

   assign dq_in = pat(re_cnt);

   function automatic logic [7:0] obs_cfg();
      return {ce_n, cle, ale, fan, led[3], led[1], led[2], led[0]};
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // NAND read model: next byte presented after each read-enable rise
   initial forever begin
      @(posedge re_n);
      if (mon_en) re_cnt++;
   end

   // scoreboard monitor for NAND writes
   initial forever begin
      @(posedge we_n);
      if (mon_en) begin
         we_cnt++;
         if (wq.size() == 0) begin
            check(1'b0, "R5", "unexpected write strobe", int'(dq_out), 0);
         end else begin
            logic [7:0] e;
            e = wq.pop_front();
            check(dq_out == e, "R4", "nand write data", int'(dq_out), int'(e));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic half_wait();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_begin();
      @(negedge clk);
      cs_n = 1'b0;
      half_wait();
   endtask

   task automatic cs_end();
      half_wait();
      cs_n = 1'b1;
      repeat (3 * HALF) @(negedge clk);
   endtask

   task automatic xfer1(input logic [7:0] tx, output logic [7:0] rx, input int nbits = 8);
      rx = '0;
      for (int i = 7; i >= 8 - nbits; i--) begin
         io0 = tx[i];
         half_wait();
         sclk = 1'b1;
         rx[i] = miso;
         half_wait();
         sclk = 1'b0;
      end
   endtask

   task automatic xfer2(input logic [7:0] tx, input int npairs = 4);
      for (int p = 3; p >= 4 - npairs; p--) begin
         io1 = tx[2*p+1];
         io0 = tx[2*p];
         half_wait();
         sclk = 1'b1;
         half_wait();
         sclk = 1'b0;
      end
      io1 = 1'b0;
   endtask

   task automatic cfg_frame(input logic [7:0] b);
      logic [7:0] r;
      cs_begin();
      xfer1(8'h09, r);
      xfer1(b, r);
      cs_end();
   endtask

   task automatic op_frame(input logic [7:0] op);
      logic [7:0] r;
      cs_begin();
      xfer1(op, r);
      cs_end();
   endtask

   task automatic write_frame(input logic [7:0] a, input logic [7:0] b,
                              input logic [7:0] c, input int n);
      logic [7:0] r;
      logic [7:0] v[3];
      int w0;
      v[0] = a; v[1] = b; v[2] = c;
      w0 = we_cnt;
      cs_begin();
      xfer1(8'h08, r);
      for (int i = 0; i < n; i++) begin
         wq.push_back(v[i]);
         xfer2(v[i]);
      end
      xfer2(8'hFF);
      cs_end();
      check(we_cnt - w0 == n, "R5", "write strobes per frame", we_cnt - w0, n);
      check(wq.size() == 0, "R4", "write queue drained", wq.size(), 0);
   endtask

   task automatic read_frame(input logic [7:0] op, input int nskip, input int n,
                             input string req);
      logic [7:0] r;
      int k0;
      k0 = re_cnt;
      cs_begin();
      xfer1(op, r);
      for (int i = 0; i < nskip; i++) xfer1(8'h00, r);
      for (int i = 0; i < n; i++) begin
         xfer1(8'h00, r);
         check(r == pat(k0 + i), req, "read byte on miso", int'(r), int'(pat(k0 + i)));
      end
      cs_end();
      check(re_cnt - k0 == n + 1, req, "read strobes incl prefetch", re_cnt - k0, n + 1);
   endtask

   initial begin
      logic [7:0] r;
      int w0, r0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      mon_en = 1'b1;

      // R1 reset state
      check(obs_cfg() == 8'h80, "R1", "control outputs after reset", int'(obs_cfg()), 8'h80);
      check(led[4] == 1'b0, "R1", "led5 after reset", int'(led[4]), 0);
      check(we_n && re_n, "R1", "strobes idle after reset", int'({we_n, re_n}), 3);
      check(miso == 1'b0, "R1", "miso after reset", int'(miso), 0);

      // R2 control register loads and bit map
      cfg_frame(8'h5A);
      check(obs_cfg() == 8'h5A, "R2", "control map 5A", int'(obs_cfg()), 8'h5A);
      cfg_frame(8'hA5);
      check(obs_cfg() == 8'hA5, "R2", "control map A5", int'(obs_cfg()), 8'hA5);
      cfg_frame(8'h06);
      check({led[2], led[1]} == 2'b11 && led[0] == 1'b0, "R2", "led2/led3 swap",
            int'(led), 6);

      // R3 LED5 set/clear
      op_frame(8'h0C);
      check(led[4] == 1'b1, "R3", "led5 on", int'(led[4]), 1);
      check(obs_cfg() == 8'h06, "R3", "control kept on led5 on", int'(obs_cfg()), 8'h06);
      op_frame(8'h0D);
      check(led[4] == 1'b0, "R3", "led5 off", int'(led[4]), 0);

      // R4 / R5 dual-line writes
      write_frame(8'hC3, 8'h5A, 8'h81, 3);
      write_frame(8'h7E, 8'h00, 8'h00, 1);
      check(dq_out == 8'h7E, "R4", "last data held", int'(dq_out), 8'h7E);

      // R6 normal read, R7 fast read
      read_frame(8'h0A, 1, 3, "R6");
      read_frame(8'h0B, 4, 2, "R7");
      check(miso == 1'b0, "R11", "miso idle after read", int'(miso), 0);

      // R8 abort inside the config data byte
      cfg_frame(8'h3C);
      cs_begin();
      xfer1(8'h09, r);
      xfer1(8'hC1, r, 5);
      cs_end();
      check(obs_cfg() == 8'h3C, "R8", "control kept after abort", int'(obs_cfg()), 8'h3C);
      // abort inside the opcode, then fresh frame
      cs_begin();
      xfer1(8'h0C, r, 3);
      cs_end();
      check(led[4] == 1'b0, "R8", "led5 kept after opcode abort", int'(led[4]), 0);
      cfg_frame(8'h99);
      check(obs_cfg() == 8'h99, "R8", "fresh frame after abort", int'(obs_cfg()), 8'h99);
      // abort inside a write payload
      w0 = we_cnt;
      cs_begin();
      xfer1(8'h08, r);
      wq.push_back(8'hB4);
      xfer2(8'hB4);
      xfer2(8'h2D);
      xfer2(8'hE7, 2);
      cs_end();
      check(we_cnt - w0 == 1, "R8", "writes after payload abort", we_cnt - w0, 1);

      // R10 unknown opcode
      w0 = we_cnt; r0 = re_cnt;
      cs_begin();
      xfer1(8'h42, r);
      xfer1(8'h09, r);
      xfer1(8'h0C, r);
      cs_end();
      check(obs_cfg() == 8'h99 && led[4] == 1'b0, "R10", "outputs after unknown opcode",
            int'({led[4], obs_cfg()}), 9'h099);
      check(we_cnt == w0 && re_cnt == r0, "R10", "no strobes on unknown opcode",
            (we_cnt - w0) + (re_cnt - r0), 0);

      // R9 strobe width and exclusion are covered by the bound checker
      check(we_n && re_n, "R9", "strobes idle at end", int'({we_n, re_n}), 3);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule